// File: doc/BRIEF.md
# Coordinate-Aligned Sparse Dot Product Unit

This block forms the dot product of two sparse vectors A and B. Each vector sits in a pair of arrays that the caller owns: one array holds the coordinates in strictly ascending order, and the other holds the matching payloads. The unit reads both arrays through asynchronous read ports and walks them as a merge-style intersection.

On every step, an alignment stage compares the current A coordinate with the current B coordinate. It routes the payloads through multiplexers that put a zero in place of whichever operand is missing. It then decides whether a multiply-accumulate is spent, gated, or avoided entirely. The skipping mode has a second B read port, so it can look one element ahead and pass over an unmatched B coordinate without losing a cycle.

A run starts with a single-cycle start pulse. The caller supplies both element counts and a mode code. The unit then presents the accumulated sum and four event counters, qualified by a valid/ready pair. Back-pressure rule: once `res_valid` is high, the result and all counters stay frozen until a cycle in which `res_ready` is high. The unit then returns to idle. A start pulse is accepted only while idle, which means neither busy nor holding a result.

Top module: `sparse_dot_unit`

## Requirements
- R1: After reset, `busy` and `res_valid` are low and `res_acc` and all four counters read zero. Accepting a start clears the sum and all counters.
- R2: A start pulse is accepted only when the unit is idle. A start seen while busy or while a result is pending is ignored.
- R3: Coordinates must be strictly ascending. On each step:
  - If the coordinates are equal, both pointers advance.
  - Otherwise, the pointer with the smaller coordinate advances.
  - The run ends as soon as either pointer reaches its element count.
  - `res_acc` equals the sum of A-payload times B-payload over all equal coordinate pairs.
- R4: Mode 2'b00 (baseline) spends a compute slot on every step. For a mismatched pair, the missing operand is replaced by zero. `res_n_act` counts every step and `res_n_gate`/`res_n_skip` stay zero.
- R5: Mode 2'b01 (gating) counts a step in `res_n_act` only for an equal-coordinate pair whose two payloads are both nonzero. Every other step is counted in `res_n_gate` and adds nothing to the sum.
- R6: Mode 2'b10 (skipping) behaves as follows:
  - An unmatched element that is passed over counts in `res_n_skip` and uses no compute slot.
  - An equal pair with a zero payload is gated, never skipped.
  - If the A coordinate equals the B element one position ahead, the unit skips the current B element and computes with the next one in the same step, advancing B by two.
- R7: `res_n_cyc` counts intersection steps. After the start is accepted, `busy` is high for `res_n_cyc`+1 cycles, and then `res_valid` rises.
- R8: `res_valid` and the result values stay unchanged while `res_ready` is low. A cycle with `res_ready` high returns the unit to idle on the next cycle.
- R9: Mode code 2'b11 behaves exactly as baseline.
- R10: An element count of zero on either operand gives a zero sum and zero counters, and the result becomes valid two cycles after the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled while idle |
| mode | input | 2 | 00 baseline, 01 gating, 10 skipping, 11 baseline |
| a_len | input | IDX_W+1 | Number of A elements |
| b_len | input | IDX_W+1 | Number of B elements |
| a_addr | output | IDX_W | Read index into the A arrays |
| a_crd | input | CRD_W | A coordinate at `a_addr` |
| a_pay | input | PAY_W | A payload at `a_addr` |
| b_addr | output | IDX_W | Read index into the B arrays |
| b_crd | input | CRD_W | B coordinate at `b_addr` |
| b_pay | input | PAY_W | B payload at `b_addr` |
| b_addr_nx | output | IDX_W | Look-ahead read index, `b_addr`+1 |
| b_crd_nx | input | CRD_W | B coordinate at `b_addr_nx` |
| b_pay_nx | input | PAY_W | B payload at `b_addr_nx` |
| busy | output | 1 | Intersection in progress |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result accepted |
| res_acc | output | 2*PAY_W+IDX_W+1 | Accumulated dot product |
| res_n_act | output | IDX_W+2 | Performed computes |
| res_n_gate | output | IDX_W+2 | Gated computes |
| res_n_skip | output | IDX_W+2 | Skipped elements |
| res_n_cyc | output | IDX_W+2 | Intersection steps |

## Verification
The bench runs each pattern in all four mode codes and compares every cycle against a behavioural model of the intersection. The patterns and what each one exposes:

- **Short vector with a B element ahead of the first match.** This tells baseline apart from gating through the gated count. It tells skipping apart from both through the one-step saving from look-ahead.
- **Equal coordinates carrying explicit zero payloads.** These show that such pairs are gated rather than skipped.
- **Disjoint coordinate sets.** These separate the zero-substituted slots of baseline from the skip counts.
- **Patterns where one operand runs out long before the other.** These pin down termination.
- **Empty operands, full-length vectors and random sparse vectors.** These cover the count boundaries and the pointer arithmetic.
- **A start pulse injected mid-run, and a result held under back-pressure.** These check acceptance and hold behaviour.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic [1:0] {
    MODE_BASE = 2'b00,
    MODE_GATE = 2'b01,
    MODE_SKIP = 2'b10,
    MODE_ALT  = 2'b11
  } sdp_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_DONE = 2'b10
  } sdp_state_e;

  // decision of the alignment stage for one intersection step
  typedef struct packed {
    logic       adv_a;
    logic [1:0] adv_b;
    logic       do_mac;
    logic       ev_act;
    logic       ev_gate;
    logic       ev_skip;
  } sdp_step_t;

  localparam int NUM_EV = 4; // act, gate, skip, cycle
endpackage

// File: rtl/sdp_align.sv
module sdp_align
  import sdp_pkg::*;
#(
  parameter int CRD_W = 8,
  parameter int PAY_W = 8
) (
  input  sdp_mode_e          mode,
  input  logic [CRD_W-1:0]   a_crd,
  input  logic [PAY_W-1:0]   a_pay,
  input  logic [CRD_W-1:0]   b_crd0,
  input  logic [PAY_W-1:0]   b_pay0,
  input  logic [CRD_W-1:0]   b_crd1,
  input  logic [PAY_W-1:0]   b_pay1,
  input  logic               b1_ok,
  output logic [PAY_W-1:0]   op_a,
  output logic [PAY_W-1:0]   op_b,
  output sdp_step_t          step
);
  logic skip_m, gate_m, eq0, eq1, lt, pair, nz;

  always_comb begin
    skip_m = (mode == MODE_SKIP);
    gate_m = (mode == MODE_GATE);
    eq0    = (a_crd == b_crd0);
    lt     = (a_crd < b_crd0);
    eq1    = skip_m && b1_ok && !eq0 && (a_crd == b_crd1);
    op_a   = '0;
    op_b   = '0;
    pair   = 1'b0;
    step   = '0;
    // operand alignment multiplexers
    if (eq0) begin
      op_a = a_pay;  op_b = b_pay0;
      step.adv_a = 1'b1; step.adv_b = 2'd1; pair = 1'b1;
    end else if (eq1) begin
      op_a = a_pay;  op_b = b_pay1;
      step.adv_a = 1'b1; step.adv_b = 2'd2; pair = 1'b1;
      step.ev_skip = 1'b1;
    end else if (lt) begin
      op_a = a_pay;
      step.adv_a = 1'b1;
    end else begin
      op_b = b_pay0;
      step.adv_b = 2'd1;
    end
    nz = (|op_a) && (|op_b);
    // compute slot policy
    if (skip_m) begin
      if (pair) begin
        step.do_mac  = nz;
        step.ev_act  = nz;
        step.ev_gate = !nz;
      end else begin
        step.ev_skip = 1'b1;
      end
    end else if (gate_m) begin
      step.do_mac  = pair && nz;
      step.ev_act  = pair && nz;
      step.ev_gate = !(pair && nz);
    end else begin
      step.do_mac = 1'b1;
      step.ev_act = 1'b1;
    end
  end
endmodule

// File: rtl/sdp_ctrl.sv
module sdp_ctrl
  import sdp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [IDX_W:0]   a_len,
  input  logic [IDX_W:0]   b_len,
  input  logic             res_ready,
  input  logic             adv_a,
  input  logic [1:0]       adv_b,
  output sdp_mode_e        mode_q,
  output logic [IDX_W-1:0] a_addr,
  output logic [IDX_W-1:0] b_addr,
  output logic             b1_ok,
  output logic             clear,
  output logic             step_en,
  output logic             busy,
  output logic             res_valid
);
  localparam int PTR_W = IDX_W + 1;

  sdp_state_e       state;
  logic [PTR_W-1:0] a_ptr, b_ptr, na_q, nb_q;
  logic             exhausted;

  always_comb begin
    exhausted = (a_ptr >= na_q) || (b_ptr >= nb_q);
    b1_ok     = ({1'b0, b_ptr} + (PTR_W+1)'(1)) < {1'b0, nb_q};
    clear     = (state == ST_IDLE) && start;
    step_en   = (state == ST_RUN) && !exhausted;
    busy      = (state == ST_RUN);
    res_valid = (state == ST_DONE);
    a_addr    = a_ptr[IDX_W-1:0];
    b_addr    = b_ptr[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      a_ptr  <= '0;
      b_ptr  <= '0;
      na_q   <= '0;
      nb_q   <= '0;
      mode_q <= MODE_BASE;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_RUN;
          a_ptr  <= '0;
          b_ptr  <= '0;
          na_q   <= a_len;
          nb_q   <= b_len;
          mode_q <= sdp_mode_e'(mode);
        end
        ST_RUN: if (exhausted) begin
          state <= ST_DONE;
        end else begin
          a_ptr <= a_ptr + PTR_W'(adv_a);
          b_ptr <= b_ptr + PTR_W'(adv_b);
        end
        ST_DONE: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdp_mac.sv
module sdp_mac
  import sdp_pkg::*;
#(
  parameter int PAY_W = 8,
  parameter int ACC_W = 23,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step_en,
  input  logic [PAY_W-1:0] op_a,
  input  logic [PAY_W-1:0] op_b,
  input  sdp_step_t        step,
  output logic [ACC_W-1:0] acc,
  output logic [CNT_W-1:0] cnt [NUM_EV]
);
  logic [NUM_EV-1:0] ev;
  assign ev = {1'b1, step.ev_skip, step.ev_gate, step.ev_act};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      acc <= '0;
    else if (clear)                  acc <= '0;
    else if (step_en && step.do_mac) acc <= acc + ACC_W'(op_a) * ACC_W'(op_b);
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_evcnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt[g] <= '0;
      else if (clear)             cnt[g] <= '0;
      else if (step_en && ev[g])  cnt[g] <= cnt[g] + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sparse_dot_unit.sv
module sparse_dot_unit
  import sdp_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CRD_W = 8,
  parameter int PAY_W = 8,
  localparam int ACC_W = 2*PAY_W + IDX_W + 1,
  localparam int CNT_W = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [IDX_W:0]   a_len,
  input  logic [IDX_W:0]   b_len,
  output logic [IDX_W-1:0] a_addr,
  input  logic [CRD_W-1:0] a_crd,
  input  logic [PAY_W-1:0] a_pay,
  output logic [IDX_W-1:0] b_addr,
  input  logic [CRD_W-1:0] b_crd,
  input  logic [PAY_W-1:0] b_pay,
  output logic [IDX_W-1:0] b_addr_nx,
  input  logic [CRD_W-1:0] b_crd_nx,
  input  logic [PAY_W-1:0] b_pay_nx,
  output logic             busy,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [ACC_W-1:0] res_acc,
  output logic [CNT_W-1:0] res_n_act,
  output logic [CNT_W-1:0] res_n_gate,
  output logic [CNT_W-1:0] res_n_skip,
  output logic [CNT_W-1:0] res_n_cyc
);
  sdp_mode_e        mode_q;
  sdp_step_t        step;
  logic [PAY_W-1:0] op_a, op_b;
  logic             b1_ok, clear, step_en;
  logic [CNT_W-1:0] cnt [NUM_EV];

  sdp_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .a_len(a_len), .b_len(b_len), .res_ready(res_ready),
    .adv_a(step.adv_a), .adv_b(step.adv_b), .mode_q(mode_q),
    .a_addr(a_addr), .b_addr(b_addr), .b1_ok(b1_ok), .clear(clear),
    .step_en(step_en), .busy(busy), .res_valid(res_valid)
  );

  assign b_addr_nx = b_addr + IDX_W'(1);

  sdp_align #(.CRD_W(CRD_W), .PAY_W(PAY_W)) u_align (
    .mode(mode_q), .a_crd(a_crd), .a_pay(a_pay),
    .b_crd0(b_crd), .b_pay0(b_pay), .b_crd1(b_crd_nx), .b_pay1(b_pay_nx),
    .b1_ok(b1_ok), .op_a(op_a), .op_b(op_b), .step(step)
  );

  sdp_mac #(.PAY_W(PAY_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step_en(step_en),
    .op_a(op_a), .op_b(op_b), .step(step), .acc(res_acc), .cnt(cnt)
  );

  assign res_n_act  = cnt[0];
  assign res_n_gate = cnt[1];
  assign res_n_skip = cnt[2];
  assign res_n_cyc  = cnt[3];
endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
  parameter int IDX_W = 6,
  parameter int PAY_W = 8,
  localparam int ACC_W = 2*PAY_W + IDX_W + 1,
  localparam int CNT_W = IDX_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             res_valid,
  input logic             res_ready,
  input logic [ACC_W-1:0] res_acc,
  input logic [CNT_W-1:0] res_n_act,
  input logic [CNT_W-1:0] res_n_gate,
  input logic [CNT_W-1:0] res_n_cyc
);
  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !res_valid |=> busy && res_acc == '0 && res_n_cyc == '0);

  assert_status_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && res_valid));

  assert_slot_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, res_n_act} + {1'b0, res_n_gate}) <= {1'b0, res_n_cyc});

  assert_cycle_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (res_n_cyc == $past(res_n_cyc)) || (res_n_cyc == $past(res_n_cyc) + CNT_W'(1)));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_acc) && $stable(res_n_cyc) && $stable(res_n_act));

  assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> !res_valid && !busy);
endmodule

bind sparse_dot_unit sdp_checker #(.IDX_W(IDX_W), .PAY_W(PAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .res_valid(res_valid),
  .res_ready(res_ready), .res_acc(res_acc), .res_n_act(res_n_act),
  .res_n_gate(res_n_gate), .res_n_cyc(res_n_cyc)
);

// File: tb/tb_sparse_dot_unit.sv
module tb_sparse_dot_unit;
  localparam int IDX_W = 6;
  localparam int CRD_W = 8;
  localparam int PAY_W = 8;
  localparam int ACC_W = 2*PAY_W + IDX_W + 1;
  localparam int CNT_W = IDX_W + 2;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [IDX_W:0] a_len = '0, b_len = '0;
  logic [IDX_W-1:0] a_addr, b_addr, b_addr_nx;
  logic [CRD_W-1:0] a_crd, b_crd, b_crd_nx;
  logic [PAY_W-1:0] a_pay, b_pay, b_pay_nx;
  logic busy, res_valid;
  logic res_ready = 1'b0;
  logic [ACC_W-1:0] res_acc;
  logic [CNT_W-1:0] res_n_act, res_n_gate, res_n_skip, res_n_cyc;

  logic [CRD_W-1:0] m_ac [DEPTH];
  logic [PAY_W-1:0] m_ap [DEPTH];
  logic [CRD_W-1:0] m_bc [DEPTH];
  logic [PAY_W-1:0] m_bp [DEPTH];

  assign a_crd    = m_ac[a_addr];
  assign a_pay    = m_ap[a_addr];
  assign b_crd    = m_bc[b_addr];
  assign b_pay    = m_bp[b_addr];
  assign b_crd_nx = m_bc[b_addr_nx];
  assign b_pay_nx = m_bp[b_addr_nx];

  always #2 clk = ~clk;

  sparse_dot_unit #(.IDX_W(IDX_W), .CRD_W(CRD_W), .PAY_W(PAY_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .a_len(a_len), .b_len(b_len),
    .a_addr(a_addr), .a_crd(a_crd), .a_pay(a_pay),
    .b_addr(b_addr), .b_crd(b_crd), .b_pay(b_pay),
    .b_addr_nx(b_addr_nx), .b_crd_nx(b_crd_nx), .b_pay_nx(b_pay_nx),
    .busy(busy), .res_valid(res_valid), .res_ready(res_ready),
    .res_acc(res_acc), .res_n_act(res_n_act), .res_n_gate(res_n_gate),
    .res_n_skip(res_n_skip), .res_n_cyc(res_n_cyc)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference for one run
  longint e_acc;
  int e_act, e_gate, e_skip, e_cyc;

  task automatic model(input int md, input int na, input int nb);
    int i = 0;
    int j = 0;
    e_acc = 0; e_act = 0; e_gate = 0; e_skip = 0; e_cyc = 0;
    while (i < na && j < nb) begin
      bit matched = 1'b0;
      int pa = 0;
      int pb = 0;
      e_cyc++;
      if (m_ac[i] == m_bc[j]) begin
        matched = 1'b1; pa = m_ap[i]; pb = m_bp[j]; i++; j++;
      end else if (md == 2 && j + 1 < nb && m_ac[i] == m_bc[j+1]) begin
        matched = 1'b1; pa = m_ap[i]; pb = m_bp[j+1]; e_skip++; i++; j += 2;
      end else if (m_ac[i] < m_bc[j]) i++;
      else j++;
      if (matched) e_acc += longint'(pa) * longint'(pb);
      if (md == 2) begin
        if (!matched) e_skip++;
        else if (pa != 0 && pb != 0) e_act++;
        else e_gate++;
      end else if (md == 1) begin
        if (matched && pa != 0 && pb != 0) e_act++;
        else e_gate++;
      end else e_act++;
    end
  endtask

  function automatic string mode_tag(int md);
    case (md)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R9";
    endcase
  endfunction

  // run one intersection and compare each clock against the model
  task automatic run_case(input int md, input int na, input int nb, input bit poke_start);
    string mt = mode_tag(md);
    model(md, na, nb);
    @(negedge clk);
    mode = md[1:0]; a_len = (IDX_W+1)'(na); b_len = (IDX_W+1)'(nb); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= e_cyc + 1; k++) begin
      chk("R7", "busy", busy, 1);
      chk("R7", "res_valid early", res_valid, 0);
      if (poke_start && k == 1) start = 1'b1;     // R2: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    chk("R7", "res_valid", res_valid, 1);
    chk("R7", "busy after", busy, 0);
    chk("R3", "sum", res_acc, e_acc);
    chk(mt, "n_act", res_n_act, e_act);
    chk(mt, "n_gate", res_n_gate, e_gate);
    chk(mt, "n_skip", res_n_skip, e_skip);
    chk("R7", "n_cyc", res_n_cyc, e_cyc);
    if (poke_start) start = 1'b1;                 // R2: ignored while result pending
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      start = 1'b0;
      chk("R8", "held valid", res_valid, 1);
      chk("R8", "held sum", res_acc, e_acc);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R8", "idle valid", res_valid, 0);
    chk("R2", "idle busy", busy, 0);
  endtask

  task automatic clear_mem;
    for (int k = 0; k < DEPTH; k++) begin
      m_ac[k] = '1; m_ap[k] = '0; m_bc[k] = '1; m_bp[k] = '0;
    end
  endtask

  task automatic all_modes(input int na, input int nb);
    for (int md = 0; md < 4; md++) run_case(md, na, nb, 1'b0);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset valid", res_valid, 0);
    chk("R1", "reset sum", res_acc, 0);
    chk("R1", "reset n_act", res_n_act, 0);
    chk("R1", "reset n_cyc", res_n_cyc, 0);
    rst_n = 1'b1;

    // short example: A{2,3}, B{1,2,3}; sum 3*11 + 5*13 = 98
    m_ac[0] = 2; m_ap[0] = 3; m_ac[1] = 3; m_ap[1] = 5;
    m_bc[0] = 1; m_bp[0] = 7; m_bc[1] = 2; m_bp[1] = 11; m_bc[2] = 3; m_bp[2] = 13;
    all_modes(2, 3);
    run_case(2, 2, 3, 1'b0);
    chk("R6", "example sum", res_acc, 98);
    chk("R6", "example steps", res_n_cyc, 2);

    // explicit zero payloads on equal coordinates
    clear_mem();
    m_ac[0] = 1; m_ap[0] = 0; m_ac[1] = 4; m_ap[1] = 2; m_ac[2] = 6; m_ap[2] = 9;
    m_bc[0] = 1; m_bp[0] = 5; m_bc[1] = 4; m_bp[1] = 0; m_bc[2] = 6; m_bp[2] = 3; m_bc[3] = 8; m_bp[3] = 1;
    all_modes(3, 4);

    // disjoint coordinates
    clear_mem();
    for (int k = 0; k < 3; k++) begin
      m_ac[k] = CRD_W'(2*k + 1); m_ap[k] = PAY_W'(k + 1);
      m_bc[k] = CRD_W'(2*k + 2); m_bp[k] = PAY_W'(k + 4);
    end
    all_modes(3, 3);

    // A exhausts early against a long B with gaps
    clear_mem();
    m_ac[0] = 10; m_ap[0] = 6; m_ac[1] = 20; m_ap[1] = 7;
    for (int k = 0; k < 8; k++) begin
      m_bc[k] = CRD_W'(5*(k + 1)); m_bp[k] = PAY_W'(k + 2);
    end
    all_modes(2, 8);

    // empty operands (R10)
    run_case(0, 0, 8, 1'b0);
    chk("R10", "empty A sum", res_acc, 0);
    chk("R10", "empty A steps", res_n_cyc, 0);
    run_case(2, 2, 0, 1'b0);
    chk("R10", "empty B steps", res_n_cyc, 0);

    // start pulses during a run and while holding a result (R2)
    run_case(1, 2, 8, 1'b1);

    // full length vectors
    clear_mem();
    for (int k = 0; k < DEPTH; k++) begin
      m_ac[k] = CRD_W'(2*k); m_ap[k] = PAY_W'(k + 1);
      m_bc[k] = CRD_W'(3*k); m_bp[k] = PAY_W'(255 - k);
    end
    all_modes(DEPTH, DEPTH);

    // random sparse vectors
    for (int t = 0; t < 6; t++) begin
      int ca = 0;
      int cb = 0;
      clear_mem();
      for (int k = 0; k < 40; k++) begin
        ca += $urandom_range(1, 5); cb += $urandom_range(1, 5);
        m_ac[k] = CRD_W'(ca); m_ap[k] = PAY_W'($urandom_range(0, 255));
        m_bc[k] = CRD_W'(cb); m_bp[k] = PAY_W'($urandom_range(0, 255));
        if ($urandom_range(0, 7) == 0) m_ap[k] = '0;
      end
      all_modes(40, int'($urandom_range(20, 40)));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule